// File: doc/BRIEF.md
# DRAM Reclock Command Sequencer

This block moves a DRAM device through a safe memory-clock change. A single start pulse launches the sequence. On that same cycle the block captures a memory-type code and the present and desired contents of mode registers 0, 1 and 2. It then steps through a fixed program of command strobes, each lasting one cycle:
- precharge-all
- refresh
- auto-refresh on and off
- self-refresh enter and exit
- mode-register writes, which carry a register index and data
- a request to change the clock
- a request to load the timing registers

Between some of these steps the block waits a set number of clock cycles, and that number depends on the memory type.

Some steps are conditional. Which of them run depends on the DLL-off bit of mode register 1 in both its present and desired state. Mode registers are rewritten only when their value changes. The block writes no mode register 2 for DDR2 parts. When the sequence ends, the block raises a one-cycle done pulse. If the memory type is unsupported, it raises a one-cycle error pulse and issues no command.

Top module: `dram_reclock_seq`

## Requirements
- R1: While reset is held and right after it, busy, done, error and every command strobe are low.
- R2: mem_type codes are 0 = DDR2, 1 = DDR3, 2 = GDDR3, 3 = unsupported. A start with code 3 gives one error pulse on the next cycle. It issues no command and busy stays low.
- R3: The DLL-off bit of MR1 is bit 0 for DDR2 and DDR3, and bit 6 for GDDR3. If that bit is clear now but set in the target, the sequence opens with two commands: a precharge, then an MR1 write of the present value with the off bit set, followed by the mode-set wait.
- R4: Self-refresh entry is precharge, refresh, refresh, auto-refresh off, then self-refresh on. A wait of T_SRE_DDR3 follows, which applies to DDR3 only and is zero otherwise.
- R5: Next comes one clock-change strobe and the exit-settle wait. Then precharge, self-refresh off and auto-refresh on. Then a wait of twice T_XS_DDR3, which applies to DDR3 only.
- R6: Mode registers are then written in the order MR2, MR1, MR0. Each is written only if its target differs from its present value, and each write is followed by the mode-set wait. DDR2 never gets an MR2 write.
- R7: In that MR1 update the DLL-off bit keeps its present value while all other bits take the target.
- R8: A timing-load strobe follows the mode-register updates.
- R9: If the target DLL-off bit is clear, the DLL is reset. First comes a full target MR1 write, but only if the off bit is set now. Then MR0 is written with bit 8 set, and then MR0 is written with bit 8 clear. The last of these writes waits the mode-set time plus the lock time: 2000, 12000 or 40000 cycles by default for DDR2, DDR3 and GDDR3.
- R10: For GDDR3 only, a last precharge follows the DLL lock wait.
- R11: A command with wait W is followed by the next command exactly W+1 cycles later, so a zero wait costs no cycle.
- R12: Busy is high from the cycle after start until the last step. Done is a single-cycle pulse that comes W+1 cycles after the last command, where W is that command's wait.
- R13: A start pulse seen while busy is ignored. The run already in progress continues with its captured inputs, and no new run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse |
| mem_type | input | 2 | Memory type code |
| cur_mr0 | input | DW | Present MR0 |
| cur_mr1 | input | DW | Present MR1 |
| cur_mr2 | input | DW | Present MR2 |
| tgt_mr0 | input | DW | Desired MR0 |
| tgt_mr1 | input | DW | Desired MR1 |
| tgt_mr2 | input | DW | Desired MR2 |
| busy | output | 1 | Sequence running |
| done | output | 1 | End pulse |
| error | output | 1 | Unsupported-type pulse |
| cmd_pre | output | 1 | Precharge-all strobe |
| cmd_ref | output | 1 | Refresh strobe |
| cmd_aref_on | output | 1 | Auto-refresh enable strobe |
| cmd_aref_off | output | 1 | Auto-refresh disable strobe |
| cmd_sr_on | output | 1 | Self-refresh enter strobe |
| cmd_sr_off | output | 1 | Self-refresh exit strobe |
| cmd_mrs | output | 1 | Mode-register write strobe |
| mrs_idx | output | 2 | Mode-register index |
| mrs_data | output | DW | Mode-register data |
| cmd_clk_chg | output | 1 | Clock-change request strobe |
| cmd_tim_load | output | 1 | Timing-load request strobe |

## Verification
The bench uses scaled wait values: mode-set 3, DLL lock 5, 7 and 11 for the three types, self-refresh entry 4, exit-to-valid 2, and exit-settle 0. Each of these values is distinct, so a wrong type-to-wait mapping shows up as a wrong gap between commands. The short waits also let every DLL-state combination run in a few hundred cycles for each memory type. The zero exit-settle value, together with the zero waits for non-DDR3 types, exercises the path that skips a wait and costs no cycle.

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq #(
  parameter int DW              = 32,
  parameter int CW              = 16,
  parameter int MR0_RST_BIT     = 8,
  parameter int T_MRD           = 1000,
  parameter int T_DLLK_DDR2     = 2000,
  parameter int T_DLLK_DDR3     = 12000,
  parameter int T_DLLK_GDDR3    = 40000,
  parameter int T_SRE_DDR3      = 2000,
  parameter int T_XS_DDR3       = 1000,
  parameter int T_SRX           = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mem_type,
  input  logic [DW-1:0] cur_mr0,
  input  logic [DW-1:0] cur_mr1,
  input  logic [DW-1:0] cur_mr2,
  input  logic [DW-1:0] tgt_mr0,
  input  logic [DW-1:0] tgt_mr1,
  input  logic [DW-1:0] tgt_mr2,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          cmd_pre,
  output logic          cmd_ref,
  output logic          cmd_aref_on,
  output logic          cmd_aref_off,
  output logic          cmd_sr_on,
  output logic          cmd_sr_off,
  output logic          cmd_mrs,
  output logic [1:0]    mrs_idx,
  output logic [DW-1:0] mrs_data,
  output logic          cmd_clk_chg,
  output logic          cmd_tim_load
);

  localparam int NSTEP = 19;
  localparam int SW    = $clog2(NSTEP + 1);
  localparam logic [1:0] MT_DDR2  = 2'd0;
  localparam logic [1:0] MT_DDR3  = 2'd1;
  localparam logic [1:0] MT_GDDR3 = 2'd2;
  localparam logic [1:0] MT_BAD   = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT} st_t;

  st_t           st;
  logic [SW-1:0] step;
  logic [CW-1:0] cnt;
  logic [1:0]    typ_q;
  logic [DW-1:0] c0_q, c1_q, c2_q, t0_q, t1_q, t2_q;
  logic          done_q, err_q;

  wire in_idle = (st == S_IDLE);

  wire [1:0]    s_typ = in_idle ? mem_type : typ_q;
  wire [DW-1:0] s_c0  = in_idle ? cur_mr0  : c0_q;
  wire [DW-1:0] s_c1  = in_idle ? cur_mr1  : c1_q;
  wire [DW-1:0] s_c2  = in_idle ? cur_mr2  : c2_q;
  wire [DW-1:0] s_t0  = in_idle ? tgt_mr0  : t0_q;
  wire [DW-1:0] s_t1  = in_idle ? tgt_mr1  : t1_q;
  wire [DW-1:0] s_t2  = in_idle ? tgt_mr2  : t2_q;

  wire [DW-1:0] off_m = (s_typ == MT_GDDR3) ? {{(DW-7){1'b0}}, 7'h40}
                                            : {{(DW-1){1'b0}}, 1'b1};
  wire [DW-1:0] rst_m = {{(DW-1){1'b0}}, 1'b1} << MR0_RST_BIT;
  wire cur_off = |(s_c1 & off_m);
  wire tgt_off = |(s_t1 & off_m);

  logic [NSTEP-1:0] act;
  assign act[0]    = !cur_off && tgt_off;
  assign act[1]    = !cur_off && tgt_off;
  assign act[10:2] = '1;
  assign act[11]   = (s_c2 != s_t2) && (s_typ != MT_DDR2);
  assign act[12]   = (s_c1 != s_t1);
  assign act[13]   = (s_c0 != s_t0);
  assign act[14]   = 1'b1;
  assign act[15]   = !tgt_off && cur_off;
  assign act[16]   = !tgt_off;
  assign act[17]   = !tgt_off;
  assign act[18]   = !tgt_off && (s_typ == MT_GDDR3);

  logic [SW-1:0] nxt;
  logic          nxt_ok;
  always_comb begin
    int base;
    base   = in_idle ? 0 : int'(step) + 1;
    nxt    = '0;
    nxt_ok = 1'b0;
    for (int i = NSTEP - 1; i >= 0; i--) begin
      if (act[i] && i >= base) begin
        nxt    = SW'(i);
        nxt_ok = 1'b1;
      end
    end
  end

  int dllk, sre, xs;
  always_comb begin
    case (typ_q)
      MT_DDR2: dllk = T_DLLK_DDR2;
      MT_DDR3: dllk = T_DLLK_DDR3;
      default: dllk = T_DLLK_GDDR3;
    endcase
    sre = (typ_q == MT_DDR3) ? T_SRE_DDR3 : 0;
    xs  = (typ_q == MT_DDR3) ? T_XS_DDR3  : 0;
  end

  logic [CW-1:0] wt;
  always_comb begin
    case (step)
      SW'(1), SW'(11), SW'(12), SW'(13), SW'(15), SW'(16): wt = CW'(T_MRD);
      SW'(6):  wt = CW'(sre);
      SW'(7):  wt = CW'(T_SRX);
      SW'(10): wt = CW'(2 * xs);
      SW'(17): wt = CW'(T_MRD + dllk);
      default: wt = '0;
    endcase
  end

  always_comb begin
    cmd_pre = 1'b0; cmd_ref = 1'b0; cmd_aref_on = 1'b0; cmd_aref_off = 1'b0;
    cmd_sr_on = 1'b0; cmd_sr_off = 1'b0; cmd_mrs = 1'b0; cmd_clk_chg = 1'b0;
    cmd_tim_load = 1'b0; mrs_idx = 2'd0; mrs_data = '0;
    if (st == S_CMD) begin
      case (step)
        SW'(0), SW'(2), SW'(8), SW'(18): cmd_pre = 1'b1;
        SW'(1):  begin cmd_mrs = 1'b1; mrs_idx = 2'd1; mrs_data = c1_q | off_m; end
        SW'(3), SW'(4): cmd_ref = 1'b1;
        SW'(5):  cmd_aref_off = 1'b1;
        SW'(6):  cmd_sr_on = 1'b1;
        SW'(7):  cmd_clk_chg = 1'b1;
        SW'(9):  cmd_sr_off = 1'b1;
        SW'(10): cmd_aref_on = 1'b1;
        SW'(11): begin cmd_mrs = 1'b1; mrs_idx = 2'd2; mrs_data = t2_q; end
        SW'(12): begin cmd_mrs = 1'b1; mrs_idx = 2'd1;
                       mrs_data = (t1_q & ~off_m) | (c1_q & off_m); end
        SW'(13): begin cmd_mrs = 1'b1; mrs_idx = 2'd0; mrs_data = t0_q; end
        SW'(14): cmd_tim_load = 1'b1;
        SW'(15): begin cmd_mrs = 1'b1; mrs_idx = 2'd1; mrs_data = t1_q; end
        SW'(16): begin cmd_mrs = 1'b1; mrs_idx = 2'd0; mrs_data = t0_q | rst_m; end
        SW'(17): begin cmd_mrs = 1'b1; mrs_idx = 2'd0; mrs_data = t0_q & ~rst_m; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; cnt <= '0; typ_q <= '0;
      c0_q <= '0; c1_q <= '0; c2_q <= '0; t0_q <= '0; t1_q <= '0; t2_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (mem_type == MT_BAD) begin
            err_q <= 1'b1;
          end else begin
            typ_q <= mem_type;
            c0_q <= cur_mr0; c1_q <= cur_mr1; c2_q <= cur_mr2;
            t0_q <= tgt_mr0; t1_q <= tgt_mr1; t2_q <= tgt_mr2;
            step <= nxt;
            st   <= S_CMD;
          end
        end
        S_CMD: begin
          if (wt != '0) begin
            cnt <= wt - 1'b1;
            st  <= S_WAIT;
          end else if (nxt_ok) begin
            step <= nxt;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (nxt_ok) begin
            step <= nxt;
            st   <= S_CMD;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = !in_idle;
  assign done  = done_q;
  assign error = err_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) error |-> (!busy && !done));
  // R4
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre, cmd_ref, cmd_aref_on, cmd_aref_off, cmd_sr_on,
              cmd_sr_off, cmd_mrs, cmd_clk_chg, cmd_tim_load}));
  // R4
  sr_after_aref_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_aref_off |=> cmd_sr_on);
  // R5
  pre_before_srx_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_sr_off |-> $past(cmd_pre));
  // R5
  aref_after_srx_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_sr_off |=> cmd_aref_on);

endmodule

// File: tb/dram_reclock_seq_bench.sv
module dram_reclock_seq_bench;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int P_MRD = 3, P_DL2 = 5, P_DL3 = 7, P_DLG = 11, P_SRE = 4, P_XS = 2, P_SRX = 0;
  localparam int NV = 8;
  // columns: type, c0, c1, c2, t0, t1, t2
  localparam logic [31:0] VEC [0:NV-1][0:6] = '{
    '{32'd1, 32'h10, 32'h0,  32'h5, 32'h20, 32'h1,  32'h6},
    '{32'd1, 32'h30, 32'h1,  32'h8, 32'h30, 32'h4,  32'h8},
    '{32'd0, 32'h10, 32'h2,  32'h3, 32'h40, 32'h6,  32'h7},
    '{32'd2, 32'h11, 32'h0,  32'h1, 32'h22, 32'h8,  32'h2},
    '{32'd2, 32'h5,  32'h1,  32'h9, 32'h5,  32'h41, 32'h9},
    '{32'd0, 32'h7,  32'h2,  32'h0, 32'h7,  32'h2,  32'h0},
    '{32'd2, 32'h3,  32'h40, 32'h4, 32'h3,  32'h40, 32'h4},
    '{32'd1, 32'h1,  32'h1,  32'h2, 32'h1,  32'h9,  32'h3}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mem_type = 0;
  logic [DW-1:0] cur_mr0 = 0, cur_mr1 = 0, cur_mr2 = 0, tgt_mr0 = 0, tgt_mr1 = 0, tgt_mr2 = 0;
  logic busy, done, error, cmd_pre, cmd_ref, cmd_aref_on, cmd_aref_off, cmd_sr_on, cmd_sr_off;
  logic cmd_mrs, cmd_clk_chg, cmd_tim_load;
  logic [1:0] mrs_idx;
  logic [DW-1:0] mrs_data;

  dram_reclock_seq #(.DW(DW), .T_MRD(P_MRD), .T_DLLK_DDR2(P_DL2), .T_DLLK_DDR3(P_DL3),
    .T_DLLK_GDDR3(P_DLG), .T_SRE_DDR3(P_SRE), .T_XS_DDR3(P_XS), .T_SRX(P_SRX)) u_dram_reclock_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
    .cur_mr0(cur_mr0), .cur_mr1(cur_mr1), .cur_mr2(cur_mr2),
    .tgt_mr0(tgt_mr0), .tgt_mr1(tgt_mr1), .tgt_mr2(tgt_mr2),
    .busy(busy), .done(done), .error(error), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref),
    .cmd_aref_on(cmd_aref_on), .cmd_aref_off(cmd_aref_off), .cmd_sr_on(cmd_sr_on),
    .cmd_sr_off(cmd_sr_off), .cmd_mrs(cmd_mrs), .mrs_idx(mrs_idx), .mrs_data(mrs_data),
    .cmd_clk_chg(cmd_clk_chg), .cmd_tim_load(cmd_tim_load));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // codes: 1 pre, 2 ref, 3 aref off, 4 sr on, 5 clk chg, 6 sr off, 7 aref on, 8 mrs, 9 tim load, 10 done, 11 error
  int e_code[64], e_idx[64], e_gap[64], ne, e_lastw;
  logic [DW-1:0] e_data[64];
  int o_code[64], o_idx[64], o_gap[64], no, o_stamp;
  logic [DW-1:0] o_data[64];
  logic rec = 0, saw_busy = 0, busy_bad = 0;
  int mc;

  always @(negedge clk) if (rec) begin
    mc = 0;
    if (cmd_pre) mc = 1; else if (cmd_ref) mc = 2; else if (cmd_aref_off) mc = 3;
    else if (cmd_sr_on) mc = 4; else if (cmd_clk_chg) mc = 5; else if (cmd_sr_off) mc = 6;
    else if (cmd_aref_on) mc = 7; else if (cmd_mrs) mc = 8; else if (cmd_tim_load) mc = 9;
    else if (done) mc = 10; else if (error) mc = 11;
    if (busy) saw_busy = 1;
    if (mc >= 1 && mc <= 9 && !busy) busy_bad = 1;
    if ((done || error) && busy) busy_bad = 1;
    if (mc != 0 && no < 64) begin
      o_code[no] = mc; o_idx[no] = (mc == 8) ? int'(mrs_idx) : 0;
      o_data[no] = (mc == 8) ? mrs_data : '0;
      o_gap[no] = cyc - o_stamp; o_stamp = cyc; no++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int i, input logic [DW-1:0] d, input int w);
    e_code[ne] = c; e_idx[ne] = i; e_data[ne] = d; e_gap[ne] = e_lastw + 1; e_lastw = w; ne++;
  endtask

  task automatic exp_build(input int ty, input logic [DW-1:0] c0, c1, c2, t0, t1, t2);
    logic [DW-1:0] off;
    int dl, sre, xs;
    bit co, to;
    ne = 0; e_lastw = 0;
    if (ty == 3) begin push(11, 0, 0, 0); return; end
    off = (ty == 2) ? 32'h40 : 32'h1;
    dl = (ty == 0) ? P_DL2 : (ty == 1) ? P_DL3 : P_DLG;
    sre = (ty == 1) ? P_SRE : 0;
    xs = (ty == 1) ? P_XS : 0;
    co = (c1 & off) != 0; to = (t1 & off) != 0;
    if (!co && to) begin push(1, 0, 0, 0); push(8, 1, c1 | off, P_MRD); end  // R3
    push(1, 0, 0, 0); push(2, 0, 0, 0); push(2, 0, 0, 0); push(3, 0, 0, 0);  // R4
    push(4, 0, 0, sre);
    push(5, 0, 0, P_SRX); push(1, 0, 0, 0); push(6, 0, 0, 0); push(7, 0, 0, 2 * xs);  // R5
    if (ty != 0 && c2 != t2) push(8, 2, t2, P_MRD);  // R6
    if (c1 != t1) push(8, 1, (t1 & ~off) | (c1 & off), P_MRD);  // R7
    if (c0 != t0) push(8, 0, t0, P_MRD);
    push(9, 0, 0, 0);  // R8
    if (!to) begin  // R9
      if (co) push(8, 1, t1, P_MRD);
      push(8, 0, t0 | 32'h100, P_MRD);
      push(8, 0, t0 & ~32'h100, P_MRD + dl);
      if (ty == 2) push(1, 0, 0, 0);  // R10
    end
    push(10, 0, 0, 0);
  endtask

  function automatic string vtag(input int v);
    case (v)
      0: return "R3"; 1: return "R9"; 2: return "R6"; 3: return "R10";
      4: return "R3"; 5: return "R11"; 6: return "R9"; 7: return "R7";
      8: return "R13"; default: return "R2";
    endcase
  endfunction

  task automatic run(input int v, input int ty, input logic [DW-1:0] c0, c1, c2, t0, t1, t2, input bit poke);
    int guard, nd;
    string tg;
    tg = vtag(v);
    exp_build(ty, c0, c1, c2, t0, t1, t2);
    @(negedge clk);
    no = 0; saw_busy = 0; busy_bad = 0; o_stamp = cyc; rec = 1;
    mem_type = 2'(ty); cur_mr0 = c0; cur_mr1 = c1; cur_mr2 = c2;
    tgt_mr0 = t0; tgt_mr1 = t1; tgt_mr2 = t2; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      mem_type = 2'd2; tgt_mr0 = 32'h77; tgt_mr1 = 32'h0; start = 1;
      @(negedge clk); start = 0;
    end
    guard = 0;
    while (!(no > 0 && (o_code[no-1] == 10 || o_code[no-1] == 11)) && guard < 2000) begin
      @(posedge clk); guard++;
    end
    @(negedge clk); #1;
    check(done == 0, "R12", "done width", int'(done), 0);
    nd = no;
    repeat (3) @(negedge clk);
    #1;
    check(no == nd, poke ? "R13" : "R12", "no activity after end", no, nd);
    rec = 0;
    check(no == ne, tg, "command count", no, ne);
    for (int i = 0; i < ne && i < no; i++) begin
      check(o_code[i] == e_code[i], tg, $sformatf("entry %0d code", i), o_code[i], e_code[i]);
      check(o_idx[i] == e_idx[i], "R6", $sformatf("entry %0d mr index", i), o_idx[i], e_idx[i]);
      check(o_data[i] == e_data[i], tg, $sformatf("entry %0d mr data", i), int'(o_data[i]), int'(e_data[i]));
      check(o_gap[i] == e_gap[i], "R11", $sformatf("entry %0d gap", i), o_gap[i], e_gap[i]);
    end
    check(!busy_bad, "R12", "busy framing", int'(busy_bad), 0);
    if (ty == 3) check(!saw_busy, "R2", "busy on error", int'(saw_busy), 0);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check({busy, done, error, cmd_pre, cmd_mrs, cmd_sr_on} == 0, "R1", "outputs in reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check({busy, done, error, cmd_pre, cmd_ref, cmd_aref_on, cmd_aref_off, cmd_sr_on,
           cmd_sr_off, cmd_mrs, cmd_clk_chg, cmd_tim_load} == 0, "R1", "outputs after reset", 0, 0);
    for (int v = 0; v < NV; v++)
      run(v, int'(VEC[v][0]), VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6], 1'b0);
    // R13: a second start during a run is ignored
    run(8, int'(VEC[0][0]), VEC[0][1], VEC[0][2], VEC[0][3], VEC[0][4], VEC[0][5], VEC[0][6], 1'b1);
    // R2: unsupported type
    run(9, 3, 32'h1, 32'h0, 32'h0, 32'h2, 32'h1, 32'h0, 1'b0);
    // R2: a valid run still works after an error
    run(5, int'(VEC[5][0]), VEC[5][1], VEC[5][2], VEC[5][3], VEC[5][4], VEC[5][5], VEC[5][6], 1'b0);
    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule